// File: doc/BRIEF.md
# Memory ECC Error Capture Unit

This unit sits next to the ECC checker of a DRAM controller and keeps a record of its error reports for software. Every clock the checker may raise up to four strobes: correctable or uncorrectable, each for the upper or the lower data half. With the strobes come the two 8-bit syndromes and the DRAM coordinates (beat, rank, column, bank, row) of the failing access. The unit folds the strobes into a pending-cause register. It also freezes the coordinates and syndromes of the first error that arrives after software last emptied that register.

Software reaches five 32-bit registers through a plain select/read/write port: a control word with the ECC recording enable, a cause mask, the pending-cause word (emptied by reading it), the captured location and the captured syndromes. Control, mask and cause words number their bits from the most significant end (bit 0 = weight 2^31). An interrupt line is high while any pending cause is also unmasked.

The capture logic is a two-state machine. In CAP_ARMED no record is held. The transition *take* (any enabled strobe) loads the location and syndrome and moves to CAP_HELD. In CAP_HELD the record is frozen. The transition *release* (a cause-word read with no strobe in the same cycle) returns to CAP_ARMED. The transition *retake* (a cause-word read that coincides with a strobe) reloads the record and stays in CAP_HELD.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset every register reads 0 and `irq` is low; this holds again after a reset applied mid-operation.
- R2: `reg_sel` 0 is control, with the enable at weight 0x8000_0000. `reg_sel` 1 is the mask: only weights 0x0080_0000, 0x0040_0000, 0x0020_0000 and 0x0010_0000 are stored, and every other bit reads 0. `reg_sel` 2 is the cause word, 3 the location and 4 the syndromes. A read returns data on `reg_rdata` one clock after `reg_rd`.
- R3: An enabled strobe sets its cause bit and the bit stays set until the cause word is read: uncorrectable-upper 0x0080_0000, correctable-upper 0x0040_0000, uncorrectable-lower 0x0020_0000, correctable-lower 0x0010_0000.
- R4: A cause-word read returns the value held before the read and empties the word in the same clock.
- R5: While the enable is 0, strobes set no cause bit and do not change the captured location or syndromes.
- R6: The location word is {beat[1:0], rank[2:0], column[10:0], bank[1:0], row[13:0]}, most significant first. The syndrome word is {16'b0, upper syndrome, lower syndrome}.
- R7: Only the first error after the cause word is emptied is captured. Later errors add cause bits but leave location and syndromes unchanged.
- R8: `irq` is high exactly when some cause bit and the mask bit at the same weight are both 1.
- R9: Writes to the cause, location and syndrome registers change nothing.
- R10: A strobe in the same clock as a cause-word read survives the clear as pending, and its location and syndromes are captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ue_hi | input | 1 | Uncorrectable error strobe, upper half |
| ce_hi | input | 1 | Correctable error strobe, upper half |
| ue_lo | input | 1 | Uncorrectable error strobe, lower half |
| ce_lo | input | 1 | Correctable error strobe, lower half |
| syn_hi | input | 8 | Upper-half syndrome |
| syn_lo | input | 8 | Lower-half syndrome |
| err_beat | input | 2 | Beat count of failing access |
| err_rank | input | 3 | Rank of failing access |
| err_col | input | 11 | Column of failing access |
| err_bank | input | 2 | Bank of failing access |
| err_row | input | 14 | Row of failing access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the clock after `reg_rd` |
| irq | output | 1 | Unmasked pending cause present |

## Verification
The assertions assume that every strobe, syndrome and coordinate input is synchronous to `clk`. They also assume that the coordinates and syndromes are valid in any cycle where a strobe is high, and that `reg_sel` points at a defined register whenever `reg_rd` or `reg_wr` is high. The stimulus changes every input only on falling edges. It issues one operation at a time, and the single exception is a deliberate strobe placed under a cause-word read to exercise R10. Location values are chosen with distinct bit patterns in every field, so that a misplaced field shows up as a wrong read.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
    localparam int REG_W     = 32;
    localparam int SEL_W     = 3;
    localparam int SYN_W     = 8;
    localparam int BEAT_W    = 2;
    localparam int RANK_W    = 3;
    localparam int COL_W     = 11;
    localparam int BANK_W    = 2;
    localparam int ROW_W     = 14;
    localparam int NUM_CAUSE = 4;
    // cause k (0 = ue_hi, 1 = ce_hi, 2 = ue_lo, 3 = ce_lo) sits at MSB-0 bit CAUSE_BASE+k
    localparam int CAUSE_BASE = 8;
    localparam int CAUSE_TOP  = REG_W - 1 - CAUSE_BASE;   // LSB-0 index of cause 0
    localparam int EN_BIT     = REG_W - 1;                // MSB-0 bit 0
    localparam int SYNW_W     = 2 * SYN_W;
    localparam int LOC_W      = BEAT_W + RANK_W + COL_W + BANK_W + ROW_W;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL = 3'd0,
        SEL_MASK = 3'd1,
        SEL_STAT = 3'd2,
        SEL_ADDR = 3'd3,
        SEL_SYN  = 3'd4
    } reg_sel_e;

    typedef enum logic {
        CAP_ARMED = 1'b0,
        CAP_HELD  = 1'b1
    } cap_state_e;
endpackage

// File: rtl/ecc_cap_cfg.sv
module ecc_cap_cfg
    import ecc_cap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    input  logic [REG_W-1:0]      wr_data,
    output logic                  ecc_en,
    output logic [NUM_CAUSE-1:0]  mask
);
    logic                 en_q;
    logic [NUM_CAUSE-1:0] mask_q;
    logic [NUM_CAUSE-1:0] mask_wr;

    // pick the four stored mask bits out of the write word
    genvar k;
    generate
        for (k = 0; k < NUM_CAUSE; k++) begin : g_mask_pick
            assign mask_wr[k] = wr_data[CAUSE_TOP-k];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_CTRL) en_q   <= wr_data[EN_BIT];
            if (wr_sel == SEL_MASK) mask_q <= mask_wr;
        end
    end

    assign ecc_en = en_q;
    assign mask   = mask_q;
endmodule

// File: rtl/ecc_cap_status.sv
module ecc_cap_status
    import ecc_cap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CAUSE-1:0]  cause_in,
    input  logic                  clr,
    output logic [NUM_CAUSE-1:0]  status
);
    logic [NUM_CAUSE-1:0] pend_q;
    logic [NUM_CAUSE-1:0] kept;

    assign kept = clr ? '0 : pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= kept | cause_in;
    end

    assign status = pend_q;
endmodule

// File: rtl/ecc_cap_track.sv
module ecc_cap_track
    import ecc_cap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic               clr,
    input  logic [LOC_W-1:0]   loc_in,
    input  logic [SYNW_W-1:0]  syn_in,
    output logic [LOC_W-1:0]   loc_q,
    output logic [SYNW_W-1:0]  syn_q,
    output cap_state_e         state
);
    cap_state_e state_q, state_d;
    logic       load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            CAP_ARMED: begin
                if (take) begin          // take
                    load    = 1'b1;
                    state_d = CAP_HELD;
                end
            end
            CAP_HELD: begin
                if (clr) begin
                    if (take) load = 1'b1;     // retake
                    else state_d = CAP_ARMED;  // release
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loc_q <= '0;
            syn_q <= '0;
        end else if (load) begin
            loc_q <= loc_in;
            syn_q <= syn_in;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
    import ecc_cap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ue_hi,
    input  logic                 ce_hi,
    input  logic                 ue_lo,
    input  logic                 ce_lo,
    input  logic [SYN_W-1:0]     syn_hi,
    input  logic [SYN_W-1:0]     syn_lo,
    input  logic [BEAT_W-1:0]    err_beat,
    input  logic [RANK_W-1:0]    err_rank,
    input  logic [COL_W-1:0]     err_col,
    input  logic [BANK_W-1:0]    err_bank,
    input  logic [ROW_W-1:0]     err_row,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [SEL_W-1:0]     reg_sel,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 irq
);
    logic [NUM_CAUSE-1:0] cause_raw;
    logic [NUM_CAUSE-1:0] cause_take;
    logic [NUM_CAUSE-1:0] status_q;
    logic [NUM_CAUSE-1:0] mask_q;
    logic                 ecc_en;
    logic                 stat_rd;
    logic [LOC_W-1:0]     loc_word;
    logic [SYNW_W-1:0]    syn_word;
    logic [LOC_W-1:0]     cap_loc;
    logic [SYNW_W-1:0]    cap_syn;
    cap_state_e           cap_state;
    logic [REG_W-1:0]     status_word;
    logic [REG_W-1:0]     mask_word;
    logic [REG_W-1:0]     ctrl_word;
    logic [REG_W-1:0]     rdata_q;

    assign cause_raw  = {ce_lo, ue_lo, ce_hi, ue_hi};
    assign cause_take = {NUM_CAUSE{ecc_en}} & cause_raw;
    assign stat_rd    = reg_rd && (reg_sel == SEL_STAT);
    assign loc_word   = {err_beat, err_rank, err_col, err_bank, err_row};
    assign syn_word   = {syn_hi, syn_lo};

    ecc_cap_cfg i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_sel  (reg_sel),
        .wr_data (reg_wdata),
        .ecc_en  (ecc_en),
        .mask    (mask_q)
    );

    ecc_cap_status i_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .cause_in (cause_take),
        .clr      (stat_rd),
        .status   (status_q)
    );

    ecc_cap_track i_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (|cause_take),
        .clr    (stat_rd),
        .loc_in (loc_word),
        .syn_in (syn_word),
        .loc_q  (cap_loc),
        .syn_q  (cap_syn),
        .state  (cap_state)
    );

    // place cause-ordered vectors at their MSB-0 weights
    genvar k;
    generate
        for (k = 0; k < NUM_CAUSE; k++) begin : g_word
            assign status_word[CAUSE_TOP-k] = status_q[k];
            assign mask_word[CAUSE_TOP-k]   = mask_q[k];
        end
        for (k = 0; k < REG_W; k++) begin : g_pad
            if (k > CAUSE_TOP || k <= CAUSE_TOP - NUM_CAUSE) begin : g_zero
                assign status_word[k] = 1'b0;
                assign mask_word[k]   = 1'b0;
            end
        end
    endgenerate

    assign ctrl_word = {ecc_en, {(REG_W-1){1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            case (reg_sel_e'(reg_sel))
                SEL_CTRL: rdata_q <= ctrl_word;
                SEL_MASK: rdata_q <= mask_word;
                SEL_STAT: rdata_q <= status_word;
                SEL_ADDR: rdata_q <= cap_loc;
                SEL_SYN:  rdata_q <= {{(REG_W-SYNW_W){1'b0}}, cap_syn};
                default:  rdata_q <= '0;
            endcase
        end
    end

    assign reg_rdata = rdata_q;
    assign irq       = |(status_q & mask_q);
endmodule

// File: rtl/ecc_cap_chk.sv
module ecc_cap_chk
    import ecc_cap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_rd,
    input  logic                  reg_wr,
    input  logic [SEL_W-1:0]      reg_sel,
    input  logic                  ecc_en,
    input  logic [NUM_CAUSE-1:0]  cause,
    input  logic [NUM_CAUSE-1:0]  status,
    input  logic [NUM_CAUSE-1:0]  mask,
    input  logic [LOC_W-1:0]      cap_loc,
    input  logic [SYNW_W-1:0]     cap_syn,
    input  logic                  irq
);
    logic stat_rd;
    logic any_ev;
    assign stat_rd = reg_rd && (reg_sel == SEL_STAT);
    assign any_ev  = ecc_en && (cause != '0);

    // R4
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !any_ev) |=> (status == '0));

    // R3
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((status & $past(status)) == $past(status)));

    // R5
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecc_en && !stat_rd) |=> ($stable(status) && $stable(cap_loc) && $stable(cap_syn)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status != '0) && !stat_rd) |=> ($stable(cap_loc) && $stable(cap_syn)));

    // R9
    stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_sel == SEL_STAT) && !reg_rd && !any_ev) |=> $stable(status));

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

    // R10
    coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && any_ev) |=> (status == $past(cause)));
endmodule

bind ecc_err_capture ecc_cap_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_rd  (reg_rd),
    .reg_wr  (reg_wr),
    .reg_sel (reg_sel),
    .ecc_en  (ecc_en),
    .cause   (cause_raw),
    .status  (status_q),
    .mask    (mask_q),
    .cap_loc (cap_loc),
    .cap_syn (cap_syn),
    .irq     (irq)
);

// File: tb/test_ecc_err_capture.sv
`timescale 1ns/1ps
module test_ecc_err_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ue_hi = 0, ce_hi = 0, ue_lo = 0, ce_lo = 0;
    logic [7:0]  syn_hi = 0, syn_lo = 0;
    logic [1:0]  err_beat = 0;
    logic [2:0]  err_rank = 0;
    logic [10:0] err_col = 0;
    logic [1:0]  err_bank = 0;
    logic [13:0] err_row = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [2:0]  reg_sel = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ecc_err_capture i_ecc_err_capture (
        .clk(clk), .rst_n(rst_n),
        .ue_hi(ue_hi), .ce_hi(ce_hi), .ue_lo(ue_lo), .ce_lo(ce_lo),
        .syn_hi(syn_hi), .syn_lo(syn_lo),
        .err_beat(err_beat), .err_rank(err_rank), .err_col(err_col),
        .err_bank(err_bank), .err_row(err_row),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EV = 2'd2;
    localparam logic [2:0] S_CTRL = 3'd0, S_MASK = 3'd1, S_STAT = 3'd2, S_ADDR = 3'd3, S_SYN = 3'd4;
    // {req[3:0], op[1:0], sel[2:0], ev[3:0] = {ue_hi,ce_hi,ue_lo,ce_lo}, data[31:0], exp[31:0]}
    localparam int NV = 28;
    localparam logic [76:0] VEC [NV] = '{
        {4'd1,  OP_RD, S_STAT, 4'h0, 32'h0,          32'h0},          // R1
        {4'd1,  OP_RD, S_MASK, 4'h0, 32'h0,          32'h0},          // R1
        {4'd1,  OP_RD, S_ADDR, 4'h0, 32'h0,          32'h0},          // R1
        {4'd5,  OP_EV, S_CTRL, 4'hF, 32'hFFFF_FFFF,  32'h0},          // R5
        {4'd5,  OP_RD, S_STAT, 4'h0, 32'h0,          32'h0},          // R5
        {4'd5,  OP_RD, S_ADDR, 4'h0, 32'h0,          32'h0},          // R5
        {4'd2,  OP_WR, S_CTRL, 4'h0, 32'h8000_0000,  32'h0},          // R2
        {4'd2,  OP_RD, S_CTRL, 4'h0, 32'h0,          32'h8000_0000},  // R2
        {4'd2,  OP_WR, S_MASK, 4'h0, 32'hFFFF_FFFF,  32'h0},          // R2
        {4'd2,  OP_RD, S_MASK, 4'h0, 32'h0,          32'h00F0_0000},  // R2
        {4'd6,  OP_EV, S_CTRL, 4'h4, 32'hC9AB_4567,  32'h0},          // R6
        {4'd7,  OP_EV, S_CTRL, 4'h1, 32'h1234_5678,  32'h0},          // R7
        {4'd6,  OP_RD, S_ADDR, 4'h0, 32'h0,          32'hC9AB_4567},  // R6 R7
        {4'd6,  OP_RD, S_SYN,  4'h0, 32'h0,          32'h0000_AB67},  // R6 R7
        {4'd9,  OP_WR, S_STAT, 4'h0, 32'h0,          32'h0},          // R9
        {4'd9,  OP_WR, S_ADDR, 4'h0, 32'h0,          32'h0},          // R9
        {4'd9,  OP_WR, S_SYN,  4'h0, 32'hFFFF_FFFF,  32'h0},          // R9
        {4'd9,  OP_RD, S_ADDR, 4'h0, 32'h0,          32'hC9AB_4567},  // R9
        {4'd3,  OP_RD, S_STAT, 4'h0, 32'h0,          32'h0050_0000},  // R3 R9
        {4'd4,  OP_RD, S_STAT, 4'h0, 32'h0,          32'h0},          // R4
        {4'd3,  OP_EV, S_CTRL, 4'h8, 32'h7FFF_0001,  32'h0},          // R3
        {4'd7,  OP_RD, S_ADDR, 4'h0, 32'h0,          32'h7FFF_0001},  // R7 recapture after clear
        {4'd6,  OP_RD, S_SYN,  4'h0, 32'h0,          32'h0000_FF01},  // R6
        {4'd3,  OP_RD, S_STAT, 4'h0, 32'h0,          32'h0080_0000},  // R3
        {4'd5,  OP_WR, S_CTRL, 4'h0, 32'h0,          32'h0},          // R5
        {4'd5,  OP_EV, S_CTRL, 4'h2, 32'h0000_1111,  32'h0},          // R5
        {4'd5,  OP_RD, S_STAT, 4'h0, 32'h0,          32'h0},          // R5
        {4'd5,  OP_RD, S_ADDR, 4'h0, 32'h0,          32'h7FFF_0001}   // R5
    };

    task automatic check(input int req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%08h expected=%08h", req, what, got, exp);
        end
    endtask

    task automatic drive_ev(input logic [3:0] ev, input logic [31:0] d);
        {ue_hi, ce_hi, ue_lo, ce_lo} = ev;
        {err_beat, err_rank, err_col, err_bank, err_row} = d;
        syn_hi = d[23:16];
        syn_lo = d[7:0];
    endtask

    task automatic do_wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic do_rd(input int req, input logic [2:0] sel, input logic [31:0] exp);
        @(negedge clk);
        reg_rd = 1; reg_sel = sel;
        @(negedge clk);
        reg_rd = 0;
        check(req, "register read", reg_rdata, exp);
    endtask

    task automatic do_ev(input logic [3:0] ev, input logic [31:0] d);
        @(negedge clk);
        drive_ev(ev, d);
        @(negedge clk);
        drive_ev(4'h0, d);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R0 watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        check(1, "irq after reset", {31'b0, irq}, 32'h0);   // R1

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][72:71])
                OP_WR: do_wr(VEC[i][70:68], VEC[i][63:32]);
                OP_RD: do_rd(int'(VEC[i][76:73]), VEC[i][70:68], VEC[i][31:0]);
                default: do_ev(VEC[i][67:64], VEC[i][63:32]);
            endcase
        end

        // R8: interrupt only for unmasked causes
        do_wr(S_CTRL, 32'h8000_0000);
        do_wr(S_MASK, 32'h0010_0000);
        check(8, "irq idle", {31'b0, irq}, 32'h0);
        do_ev(4'h4, 32'h0101_0202);
        check(8, "irq masked cause", {31'b0, irq}, 32'h0);
        do_ev(4'h1, 32'h0303_0404);
        check(8, "irq unmasked cause", {31'b0, irq}, 32'h1);
        do_rd(4, S_STAT, 32'h0050_0000);
        check(8, "irq after clear", {31'b0, irq}, 32'h0);

        // R10: strobe coinciding with cause-word read
        do_ev(4'h8, 32'h0ABC_DEF0);
        @(negedge clk);
        reg_rd = 1; reg_sel = S_STAT;
        drive_ev(4'h1, 32'h5555_AAAA);
        @(negedge clk);
        reg_rd = 0;
        drive_ev(4'h0, 32'h0);
        check(4, "read value before clear", reg_rdata, 32'h0080_0000);
        check(8, "irq from coincident cause", {31'b0, irq}, 32'h1);
        do_rd(10, S_ADDR, 32'h5555_AAAA);
        do_rd(10, S_SYN, 32'h0000_55AA);
        do_rd(10, S_STAT, 32'h0010_0000);

        // R1: reset in mid-operation
        do_ev(4'h2, 32'h1357_9BDF);
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        check(1, "irq after mid reset", {31'b0, irq}, 32'h0);
        do_rd(1, S_STAT, 32'h0);
        do_rd(1, S_CTRL, 32'h0);
        do_rd(1, S_ADDR, 32'h0);
        do_rd(1, S_SYN, 32'h0);

        done = 1;
        finish_run();
    end
endmodule